// File: doc/BRIEF.md
# Serially Programmed Clock Output Enable Controller

This block fans one reference clock out to six gated copies. Each copy can be turned off and held low. A receiver on a two-wire serial bus holds the enables. It accepts one fixed write transaction of ten bytes: a target byte, two filler bytes whose values do not matter, and seven payload bytes. Only three of the payload bytes carry enable bits, and those bits sit at irregular positions. The serial lines are oversampled on a system clock. The receiver drives the data line low through an open-drain pull-down to acknowledge bytes.

Each enable is carried into the reference clock domain and applied only while the reference clock is low. Switching an output on or off therefore never produces a shortened high pulse. A transfer cut short keeps every byte that was fully received and acknowledged. A start or stop condition realigns the byte position to the target byte.

Top module: `smb_clk_enable`

## Requirements
- R1: After reset all six outputs copy the reference clock and the data-line pull-down is released.
- R2: Register updates happen only when the first byte after a start equals 0xD2, with the direction bit as its least significant bit. Any other value, including 0xD3, is not acknowledged and leaves every output unchanged.
- R3: After a matching target byte, every later byte is acknowledged by pulling the data line low during the ninth serial clock. This includes the two filler bytes at positions 1 and 2, whose values have no effect.
- R4: Each byte is shifted in most significant bit first.
- R5: Payload byte 0 (byte position 3) sets the enables of outputs 0, 1 and 2 from its bits 0, 2 and 7.
- R6: Payload byte 1 (position 4) sets the enable of output 4 from bit 3 and of output 5 from bit 6. Payload byte 2 (position 5) sets the enable of output 3 from bit 7.
- R7: All other bits of payload bytes 0 to 2, and all of payload bytes 3 to 6, have no effect on any output.
- R8: An enable bit of 1 makes the output follow the reference clock. An enable bit of 0 holds the output low through both reference clock phases.
- R9: A payload byte takes effect only when its acknowledge clock completes. A byte interrupted by a stop leaves its outputs unchanged, while earlier complete bytes stay applied.
- R10: A repeated start without a stop resets the byte position, so the next byte is treated as a target byte.
- R11: An output never changes while the reference clock stays high, so enable changes create no runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock line level |
| sda_i | input | 1 | Serial bus data line level |
| ref_clk_i | input | 1 | Reference clock to be fanned out |
| clk_o | output | 6 | Gated copies of the reference clock, bit n is output n |
| sda_pd_o | output | 1 | When high, pull the serial data line low |

## Verification
The acknowledge pull-down is due about three system clocks after the serial clock falls: two synchronizer flops and one edge register. The bench waits eight system clocks before it raises the ninth clock, then samples in the middle of the high phase. A payload byte reaches the enable register about four system clocks after the ninth clock falls. It then needs two rising edges and one falling edge of the reference clock before it reaches an output, so the bench waits ten reference periods after each transfer. It then samples every output once in a high phase and once in a low phase of the reference clock. Reference clock edges fall on even nanoseconds and system clock rising edges on odd ones, so no sample is taken at an edge.

// File: rtl/smb_clk_enable_pkg.sv
package smb_clk_enable_pkg;
  localparam int unsigned NUM_OUT       = 6;
  localparam int unsigned BYTE_W        = 8;
  localparam logic [7:0]  TARGET_ADDR   = 8'hD2;
  localparam int unsigned FIRST_CFG_POS = 3;   // target, filler, filler precede payload
  localparam int unsigned NUM_CFG_BYTES = 3;
  localparam int unsigned CFG_IDX_W     = $clog2(NUM_CFG_BYTES);
  localparam int unsigned POS_W         = 4;

  // payload byte that carries the enable of output i
  function automatic int unsigned cfg_byte(int unsigned i);
    case (i)
      0, 1, 2: return 0;
      3:       return 2;
      default: return 1;
    endcase
  endfunction

  // bit within that byte
  function automatic int unsigned cfg_bit(int unsigned i);
    case (i)
      0:       return 0;
      1:       return 2;
      2, 3:    return 7;
      4:       return 3;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/smb_rx.sv
module smb_rx
  import smb_clk_enable_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_s_i,
  input  logic                 sda_s_i,
  output logic                 sda_pd_o,
  output logic                 addressed_o,
  output logic                 wr_v_o,
  output logic [CFG_IDX_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0]    wr_data_o
);
  localparam logic [POS_W-1:0] POS_MAX   = '1;
  localparam logic [POS_W-1:0] POS_FIRST = POS_W'(FIRST_CFG_POS);
  localparam logic [POS_W-1:0] POS_END   = POS_W'(FIRST_CFG_POS + NUM_CFG_BYTES);

  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [3:0]        bit_cnt;
  logic [POS_W-1:0]  pos_q;
  logic [BYTE_W-1:0] sh_q;
  logic              addr_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise  = scl_s_i & ~scl_q;
  assign scl_fall  = ~scl_s_i & scl_q;
  assign start_det = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_det  = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign addr_hit  = (sh_q == TARGET_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt     <= '0;
      pos_q       <= '0;
      sh_q        <= '0;
      sda_pd_o    <= 1'b0;
      addressed_o <= 1'b0;
      wr_v_o      <= 1'b0;
      wr_idx_o    <= '0;
      wr_data_o   <= '0;
    end else begin
      wr_v_o <= 1'b0;
      if (start_det || stop_det) begin
        bit_cnt     <= '0;
        pos_q       <= '0;
        sda_pd_o    <= 1'b0;
        addressed_o <= 1'b0;
      end else if (scl_rise) begin
        if (bit_cnt < 4'd8) begin
          sh_q    <= {sh_q[BYTE_W-2:0], sda_s_i};
          bit_cnt <= bit_cnt + 4'd1;
        end else if (bit_cnt == 4'd8) begin
          bit_cnt <= 4'd9;
        end
      end else if (scl_fall) begin
        if (bit_cnt == 4'd8) begin
          // open ack slot
          if (pos_q == '0) begin
            addressed_o <= addr_hit;
            sda_pd_o    <= addr_hit;
          end else begin
            sda_pd_o <= addressed_o;
          end
        end else if (bit_cnt == 4'd9) begin
          sda_pd_o <= 1'b0;
          bit_cnt  <= '0;
          if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
          if (addressed_o && pos_q >= POS_FIRST && pos_q < POS_END) begin
            wr_v_o    <= 1'b1;
            wr_idx_o  <= CFG_IDX_W'(pos_q - POS_FIRST);
            wr_data_o <= sh_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/en_regs.sv
module en_regs
  import smb_clk_enable_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_v_i,
  input  logic [CFG_IDX_W-1:0] wr_idx_i,
  input  logic [BYTE_W-1:0]    wr_data_i,
  output logic [NUM_OUT-1:0]   en_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_en
    localparam int unsigned BY = cfg_byte(g);
    localparam int unsigned BI = cfg_bit(g);
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      en_q <= 1'b1;
      else if (wr_v_i && wr_idx_i == CFG_IDX_W'(BY))    en_q <= wr_data_i[BI];
    end
    assign en_o[g] = en_q;
  end
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic en_s;
  logic gate_q;

  line_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (en_s)
  );

  // update only on the falling edge: gate is steady across every high phase
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= en_s;
  end

  assign clk_o = ref_clk_i & gate_q;
endmodule

// File: rtl/smb_clk_enable.sv
module smb_clk_enable
  import smb_clk_enable_pkg::*;
#(
  parameter int unsigned BUS_SYNC = 2,
  parameter int unsigned REF_SYNC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               ref_clk_i,
  output logic [NUM_OUT-1:0] clk_o,
  output logic               sda_pd_o
);
  logic                 scl_s, sda_s;
  logic                 addressed;
  logic                 wr_v;
  logic [CFG_IDX_W-1:0] wr_idx;
  logic [BYTE_W-1:0]    wr_data;
  logic [NUM_OUT-1:0]   en_q;

  line_sync #(.W(2), .STAGES(BUS_SYNC), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  smb_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_s_i    (scl_s),
    .sda_s_i    (sda_s),
    .sda_pd_o   (sda_pd_o),
    .addressed_o(addressed),
    .wr_v_o     (wr_v),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  en_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_v_i   (wr_v),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .en_o     (en_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    clk_gate_cell #(.SYNC_STAGES(REF_SYNC)) u_gate (
      .ref_clk_i(ref_clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_q[g]),
      .clk_o    (clk_o[g])
    );
  end
endmodule

// File: rtl/smb_clk_enable_chk.sv
module smb_clk_enable_chk
  import smb_clk_enable_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               ref_clk_i,
  input logic               sda_pd_o,
  input logic [NUM_OUT-1:0] clk_o,
  input logic [NUM_OUT-1:0] en_q,
  input logic               wr_v,
  input logic               addressed
);
  // R3: acknowledge drive moves only while the serial clock is low
  assert_ack_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_pd_o));

  // R2: pull-down only for a matched target
  assert_ack_needs_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pd_o |-> addressed);

  // R2: enables change only while addressed
  assert_cfg_needs_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> addressed);

  // R9: enables change only right after a completed byte
  assert_cfg_at_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q != $past(en_q)) |-> $past(wr_v));

  // R11: outputs steady through a high phase of the reference clock
  assert_no_runt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_clk_i && $past(ref_clk_i)) |-> $stable(clk_o));
endmodule

bind smb_clk_enable smb_clk_enable_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_i    (scl_i),
  .ref_clk_i(ref_clk_i),
  .sda_pd_o (sda_pd_o),
  .clk_o    (clk_o),
  .en_q     (en_q),
  .wr_v     (wr_v),
  .addressed(addressed)
);

// File: tb/tb_smb_clk_enable.sv
module tb_smb_clk_enable;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_clk = 1'b0;
  logic       scl = 1'b1;
  logic       sda_drv = 1'b1;
  logic       sda_bus;
  logic [5:0] clk_o;
  logic       sda_pd_o;
  logic       acks [10];
  int         checks = 0;
  int         fails = 0;

  assign sda_bus = sda_drv & ~sda_pd_o;

  smb_clk_enable dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .ref_clk_i(ref_clk),
    .clk_o    (clk_o),
    .sda_pd_o (sda_pd_o)
  );

  always #5 clk = ~clk;            // rising edges on odd ns
  initial begin
    #2;
    forever #22 ref_clk = ~ref_clk; // edges on even ns
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wclk(2);
    scl = 1'b1;     wclk(HALF);
    sda_drv = 1'b0; wclk(HALF);
    scl = 1'b0;     wclk(2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wclk(2);
    scl = 1'b1;     wclk(HALF);
    sda_drv = 1'b1; wclk(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      sda_drv = b[i]; wclk(HALF);
      scl = 1'b1;     wclk(HALF);
      scl = 1'b0;     wclk(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_drv = 1'b1; wclk(HALF);
    scl = 1'b1;     wclk(HALF/2);
    ack = sda_pd_o;
    wclk(HALF/2);
    scl = 1'b0;     wclk(2);
  endtask

  task automatic xfer(input logic [7:0] b [10], input int full, input int part_bits, input bit do_stop);
    logic a;
    for (int i = 0; i < 10; i++) acks[i] = 1'b0;
    bus_start();
    for (int i = 0; i < full; i++) begin
      send_byte(b[i], a);
      acks[i] = a;
    end
    if (part_bits > 0) send_bits(b[full], part_bits);
    if (do_stop) bus_stop();
  endtask

  task automatic check_outs(input string req, input logic [5:0] exp);
    repeat (10) @(posedge ref_clk);
    @(posedge ref_clk); #7;
    chk(req, 32'(clk_o), 32'(exp));
    @(negedge ref_clk); #7;
    chk(req, 32'(clk_o), 32'h0);
  endtask

  task automatic cfg(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] b [10];
    b = '{8'hD2, 8'h00, 8'h00, d0, d1, d2, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 10, 0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 pulldown", 32'(sda_pd_o), 32'h0);
    check_outs("R1 outputs", 6'h3F);
  endtask

  task automatic t_byte0_fillers();
    logic [7:0] b [10];
    b = '{8'hD2, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 10, 0, 1'b1);
    chk("R2 target ack", 32'(acks[0]), 32'h1);
    chk("R3 filler acks", 32'({acks[1], acks[2]}), 32'h3);
    chk("R3 payload acks", 32'({acks[3], acks[4], acks[5], acks[6], acks[7], acks[8], acks[9]}), 32'h7F);
    check_outs("R5 byte0 cleared", 6'h38);
  endtask

  task automatic t_map();
    cfg(8'h85, 8'h00, 8'h7F);
    check_outs("R6 byte1 byte2 cleared", 6'h07);
  endtask

  task automatic t_msb_first();
    cfg(8'h04, 8'h48, 8'h80);
    check_outs("R4 msb first", 6'h3A);
  endtask

  task automatic t_reserved();
    logic [7:0] b [10];
    b = '{8'hD2, 8'h00, 8'h00, 8'h7A, 8'hB7, 8'h7F, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    xfer(b, 10, 0, 1'b1);
    check_outs("R7 reserved ignored", 6'h00);
    check_outs("R8 all held low", 6'h00);
  endtask

  task automatic t_bad_addr();
    logic [7:0] b [10];
    cfg(8'hFF, 8'hFF, 8'hFF);
    check_outs("R8 all enabled", 6'h3F);
    b = '{8'hD0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 10, 0, 1'b1);
    chk("R2 no ack wrong addr", 32'(acks[0]), 32'h0);
    chk("R2 no ack later bytes", 32'(acks[3]), 32'h0);
    check_outs("R2 wrong addr ignored", 6'h3F);
    b[0] = 8'hD3;
    xfer(b, 10, 0, 1'b1);
    chk("R2 no ack read addr", 32'(acks[0]), 32'h0);
    check_outs("R2 read addr ignored", 6'h3F);
  endtask

  task automatic t_truncated();
    logic [7:0] b [10];
    b = '{8'hD2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 4, 7, 1'b1);
    check_outs("R9 partial byte dropped", 6'h38);
  endtask

  task automatic t_restart();
    logic [7:0] b [10];
    cfg(8'hFF, 8'hFF, 8'hFF);
    b = '{8'hD2, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 2, 0, 1'b0);
    b = '{8'hD2, 8'h00, 8'h00, 8'h01, 8'h08, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00};
    xfer(b, 10, 0, 1'b1);
    chk("R10 restart target ack", 32'(acks[0]), 32'h1);
    check_outs("R10 restart realigned", 6'h19);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wclk(5);
    rst_ni = 1'b1;
    wclk(5);
    t_reset();
    t_byte0_fillers();
    t_map();
    t_msb_first();
    t_reserved();
    t_bad_addr();
    t_truncated();
    t_restart();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule